// File: doc/BRIEF.md
# Eight-Lane Vector ALU

This unit performs one SIMD operation per issue across eight 32-bit lanes. An issue carries an opcode, three vector operands (A, B, C), one scalar operand S and an eight-bit lane mask. The unit returns a write request: a per-lane write enable and an eight-lane result word. A register file outside the unit commits that request at the next clock edge. Every read made in the same cycle therefore still sees the old contents.

Most operations are combinational. Their write request appears in the same cycle as the issue. The supported operations are:
- element-wise arithmetic, logic, shift and unsigned compare;
- a scalar broadcast;
- a fused multiply-add.

Every result wraps to an unsigned 32-bit word. Unsigned divide and remainder are the exception to single-cycle timing. They run through eight parallel restoring dividers at one quotient bit per cycle. The unit holds `busy` while they run and ignores any issue during that time. A zero divisor in an enabled lane gives a result of 0 and sets a sticky error flag.

Top module: `simd8_alu`

## Requirements
- R1: Opcodes 0 (add), 1 (subtract) and 2 (multiply) compute A op B in each lane. The result is reduced modulo 2^32.
- R2: Opcodes 4 (XOR), 5 (AND) and 6 (OR) apply the bitwise operation to A and B in each lane.
- R3: Opcodes 7 (left shift) and 8 (logical right shift) shift A by the whole 32-bit value of B. Any shift amount of 32 or more yields 0.
- R4: Opcodes 10 (unsigned less-than) and 11 (equality) write 1 when the relation holds and 0 otherwise.
- R5: Opcode 12 (broadcast) writes the scalar S into every lane.
- R6: Opcode 13 (multiply-add) writes ((A*B) mod 2^32 + C) mod 2^32 in each lane.
- R7: A single-cycle operation issued while idle presents its request in the issue cycle, with `wr_en` equal to `lane_mask`. When nothing is issued and the unit is idle, `wr_en` is 0.
- R8: Opcodes 14 and 15 are undefined and produce no write (`wr_en` = 0).
- R9: Opcodes 3 (unsigned divide, A/B) and 9 (unsigned remainder, A mod B) write nothing in the issue cycle. Their request appears exactly WIDTH+1 cycles after the issue cycle, with `wr_en` equal to the mask given at issue.
- R10: `busy` is high from the cycle after a divide or remainder issue up to and including the cycle of its write request, and low afterwards. Issues made while `busy` is high produce no write and do not disturb the pending result.
- R11: In a lane enabled at issue whose divisor B is 0, a divide or remainder writes 0 and sets `div_err` from the next cycle. `div_err` stays set until reset. A zero divisor in a masked-out lane does not set it.
- R12: While `rst_n` is low, `busy`, `div_err` and `wr_en` are 0, and any running divide or remainder is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An operation is offered this cycle |
| issue_op | input | 4 | Opcode |
| lane_mask | input | LANES | Lanes the result may write |
| src_a | input | LANES*WIDTH | Vector operand A, lane i at bits i*WIDTH upward |
| src_b | input | LANES*WIDTH | Vector operand B |
| src_c | input | LANES*WIDTH | Vector operand C (multiply-add addend) |
| src_s | input | WIDTH | Scalar operand for broadcast |
| busy | output | 1 | Divide or remainder in progress |
| wr_en | output | LANES | Per-lane write request |
| wr_data | output | LANES*WIDTH | Result lanes |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
The checker watches several properties on every clock edge:
- idle writes stay inside the lane mask and are silent when nothing is issued;
- compares only ever yield 0 or 1, and a broadcast fills every lane with the scalar;
- undefined opcodes never write;
- a divide launch raises `busy` without an immediate write, and the busy window ends right after its single write;
- the error flag never clears on its own.

Only the bench scenarios can show that the arithmetic values are right. That covers wrap-around of sums, products and multiply-add, shift amounts at and beyond the word width, and the quotient and remainder values. The scenarios also cover the exact divide latency, issues rejected during a divide, masked-out zero divisors, and a reset in the middle of a divide.

// File: rtl/simd8_pkg.sv
package simd8_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_MUL   = 4'd2,
      OP_DIV   = 4'd3,
      OP_XOR   = 4'd4,
      OP_AND   = 4'd5,
      OP_OR    = 4'd6,
      OP_SHL   = 4'd7,
      OP_SHR   = 4'd8,
      OP_MOD   = 4'd9,
      OP_LTU   = 4'd10,
      OP_EQ    = 4'd11,
      OP_BCAST = 4'd12,
      OP_FMA   = 4'd13
   } vop_e;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_DONE = 2'd2
   } seq_e;

   function automatic logic op_is_multi(input logic [3:0] op);
      return (op == OP_DIV) || (op == OP_MOD);
   endfunction

   function automatic logic op_is_single(input logic [3:0] op);
      return (op <= OP_FMA) && !op_is_multi(op);
   endfunction

endpackage

// File: rtl/simd8_lane_alu.sv
module simd8_lane_alu
   import simd8_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [WIDTH-1:0] c,
   input  logic [WIDTH-1:0] s,
   output logic [WIDTH-1:0] res
);
   localparam int SHW = $clog2(WIDTH);

   logic [WIDTH-1:0] prod;
   logic [WIDTH-1:0] shl_v;
   logic [WIDTH-1:0] shr_v;
   logic             shift_big;

   assign prod      = a * b;
   assign shift_big = |b[WIDTH-1:SHW];
   assign shl_v     = shift_big ? '0 : (a << b[SHW-1:0]);
   assign shr_v     = shift_big ? '0 : (a >> b[SHW-1:0]);

   always_comb begin
      res = '0;
      case (op)
         OP_ADD:   res = a + b;
         OP_SUB:   res = a - b;
         OP_MUL:   res = prod;
         OP_XOR:   res = a ^ b;
         OP_AND:   res = a & b;
         OP_OR:    res = a | b;
         OP_SHL:   res = shl_v;
         OP_SHR:   res = shr_v;
         OP_LTU:   res = {{(WIDTH-1){1'b0}}, (a < b)};
         OP_EQ:    res = {{(WIDTH-1){1'b0}}, (a == b)};
         OP_BCAST: res = s;
         OP_FMA:   res = prod + c;
         default:  res = '0;
      endcase
   end
endmodule

// File: rtl/simd8_div_lane.sv
module simd8_div_lane #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder
);
   logic [WIDTH-1:0] q_r;
   logic [WIDTH-1:0] r_r;
   logic [WIDTH-1:0] d_r;
   logic             z_r;
   logic [WIDTH:0]   trial;
   logic [WIDTH:0]   diff;
   logic             ge;

   assign trial = {r_r, q_r[WIDTH-1]};
   assign ge    = trial >= {1'b0, d_r};
   assign diff  = trial - {1'b0, d_r};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r <= '0;
         r_r <= '0;
         d_r <= '0;
         z_r <= 1'b0;
      end else if (load) begin
         q_r <= dividend;
         r_r <= '0;
         d_r <= divisor;
         z_r <= (divisor == '0);
      end else if (step) begin
         r_r <= ge ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
         q_r <= {q_r[WIDTH-2:0], ge};
      end
   end

   assign quotient  = z_r ? '0 : q_r;
   assign remainder = z_r ? '0 : r_r;
endmodule

// File: rtl/simd8_alu.sv
module simd8_alu
   import simd8_pkg::*;
#(
   parameter int LANES = 8,
   parameter int WIDTH = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   issue_valid,
   input  logic [3:0]             issue_op,
   input  logic [LANES-1:0]       lane_mask,
   input  logic [LANES*WIDTH-1:0] src_a,
   input  logic [LANES*WIDTH-1:0] src_b,
   input  logic [LANES*WIDTH-1:0] src_c,
   input  logic [WIDTH-1:0]       src_s,
   output logic                   busy,
   output logic [LANES-1:0]       wr_en,
   output logic [LANES*WIDTH-1:0] wr_data,
   output logic                   div_err
);
   localparam int VECW = LANES * WIDTH;
   localparam int CNTW = $clog2(WIDTH + 1);

   if (LANES < 1) begin : g_chk_lanes
      $error("simd8_alu: LANES must be at least 1");
   end
   if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_chk_width
      $error("simd8_alu: WIDTH must be a power of two, at least 2");
   end

   seq_e             state;
   logic [CNTW-1:0]  cnt;
   logic [LANES-1:0] held_mask;
   logic             held_mod;
   logic             idle;
   logic             take_multi;
   logic             take_single;
   logic [LANES-1:0] b_zero;
   logic [VECW-1:0]  fast_res;
   logic [VECW-1:0]  quo_vec;
   logic [VECW-1:0]  rem_vec;

   assign idle        = (state == SEQ_IDLE);
   assign take_multi  = issue_valid && idle && op_is_multi(issue_op);
   assign take_single = issue_valid && idle && op_is_single(issue_op);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      simd8_lane_alu #(.WIDTH(WIDTH)) u_alu (
         .op  (issue_op),
         .a   (src_a[i*WIDTH +: WIDTH]),
         .b   (src_b[i*WIDTH +: WIDTH]),
         .c   (src_c[i*WIDTH +: WIDTH]),
         .s   (src_s),
         .res (fast_res[i*WIDTH +: WIDTH])
      );

      simd8_div_lane #(.WIDTH(WIDTH)) u_div (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (take_multi),
         .step      (state == SEQ_RUN),
         .dividend  (src_a[i*WIDTH +: WIDTH]),
         .divisor   (src_b[i*WIDTH +: WIDTH]),
         .quotient  (quo_vec[i*WIDTH +: WIDTH]),
         .remainder (rem_vec[i*WIDTH +: WIDTH])
      );

      assign b_zero[i] = (src_b[i*WIDTH +: WIDTH] == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         cnt       <= '0;
         held_mask <= '0;
         held_mod  <= 1'b0;
         div_err   <= 1'b0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (take_multi) begin
                  state     <= SEQ_RUN;
                  cnt       <= CNTW'(WIDTH);
                  held_mask <= lane_mask;
                  held_mod  <= (issue_op == OP_MOD);
                  if ((lane_mask & b_zero) != '0) begin
                     div_err <= 1'b1;
                  end
               end
            end
            SEQ_RUN: begin
               cnt <= cnt - 1'b1;
               if (cnt == CNTW'(1)) begin
                  state <= SEQ_DONE;
               end
            end
            default: begin
               state <= SEQ_IDLE;
            end
         endcase
      end
   end

   always_comb begin
      wr_en   = '0;
      wr_data = fast_res;
      if (state == SEQ_DONE) begin
         wr_en   = held_mask;
         wr_data = held_mod ? rem_vec : quo_vec;
      end else if (take_single) begin
         wr_en = lane_mask;
      end
   end

   assign busy = !idle;

endmodule

// File: rtl/simd8_alu_chk.sv
module simd8_alu_chk
   import simd8_pkg::*;
#(
   parameter int LANES = 8,
   parameter int WIDTH = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   issue_valid,
   input logic [3:0]             issue_op,
   input logic [LANES-1:0]       lane_mask,
   input logic [WIDTH-1:0]       src_s,
   input logic                   busy,
   input logic [LANES-1:0]       wr_en,
   input logic [LANES*WIDTH-1:0] wr_data,
   input logic                   div_err
);
   logic cmp_ok;
   logic bcast_ok;
   logic issue_idle;

   assign issue_idle = issue_valid && !busy;

   always_comb begin
      cmp_ok   = 1'b1;
      bcast_ok = 1'b1;
      for (int i = 0; i < LANES; i++) begin
         if (wr_data[i*WIDTH+1 +: WIDTH-1] != '0) cmp_ok = 1'b0;
         if (wr_data[i*WIDTH +: WIDTH] != src_s)  bcast_ok = 1'b0;
      end
   end

   AST_MASKED_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ((wr_en & ~lane_mask) == '0)); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !issue_valid) |-> (wr_en == '0)); // R7
   AST_CMP_ZERO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_idle && (issue_op == OP_LTU || issue_op == OP_EQ)) |-> cmp_ok); // R4
   AST_BCAST_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_idle && issue_op == OP_BCAST) |-> bcast_ok); // R5
   AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_idle && issue_op > OP_FMA) |-> (wr_en == '0)); // R8
   AST_DIV_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_idle && (issue_op == OP_DIV || issue_op == OP_MOD)) |-> (wr_en == '0)); // R9
   AST_DIV_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_idle && (issue_op == OP_DIV || issue_op == OP_MOD)) |=> busy); // R10
   AST_WRITE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en != '0) |=> !busy); // R10
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      div_err |=> div_err); // R11

endmodule

bind simd8_alu simd8_alu_chk #(.LANES(LANES), .WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .issue_op    (issue_op),
   .lane_mask   (lane_mask),
   .src_s       (src_s),
   .busy        (busy),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .div_err     (div_err)
);

// File: tb/simd8_alu_test.sv
`timescale 1ns/1ps
module simd8_alu_test;
   localparam int L = 8;
   localparam int W = 32;
   localparam int NV = 18;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           issue_valid = 1'b0;
   logic [3:0]     issue_op = 4'd0;
   logic [L-1:0]   lane_mask = '0;
   logic [L*W-1:0] src_a = '0;
   logic [L*W-1:0] src_b = '0;
   logic [L*W-1:0] src_c = '0;
   logic [W-1:0]   src_s = '0;
   logic           busy;
   logic [L-1:0]   wr_en;
   logic [L*W-1:0] wr_data;
   logic           div_err;

   int checks = 0;
   int errors = 0;

   simd8_alu #(.LANES(L), .WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
      .lane_mask(lane_mask), .src_a(src_a), .src_b(src_b), .src_c(src_c),
      .src_s(src_s), .busy(busy), .wr_en(wr_en), .wr_data(wr_data),
      .div_err(div_err)
   );

   always #5 clk = ~clk;

   localparam logic [3:0] T_OP [NV] = '{
      4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd7,
      4'd8, 4'd10, 4'd10, 4'd11, 4'd11, 4'd12, 4'd13, 4'd13, 4'd14};
   localparam logic [31:0] T_A [NV] = '{
      32'hFFFFFFFF, 32'd3, 32'h00010000, 32'hF0F0F0F0, 32'hF0F0F0F0, 32'hF0F0F0F0,
      32'h80000001, 32'h80000000, 32'd1, 32'hFFFFFFFF, 32'd3, 32'hFFFFFFFF,
      32'd7, 32'd7, 32'd0, 32'h00010000, 32'hFFFFFFFF, 32'd9};
   localparam logic [31:0] T_B [NV] = '{
      32'd2, 32'd5, 32'h00010001, 32'hFF00FF00, 32'hFF00FF00, 32'hFF00FF00,
      32'd1, 32'd31, 32'd32, 32'h00000100, 32'd5, 32'd1,
      32'd7, 32'd8, 32'd0, 32'h00010000, 32'd2, 32'd9};
   localparam logic [31:0] T_C [NV] = '{
      32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0,
      32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd5, 32'd3, 32'd0};
   localparam logic [31:0] T_S [NV] = '{
      32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0,
      32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'hDEADBEEF, 32'd0, 32'd0, 32'd0};
   localparam logic [31:0] T_EXP [NV] = '{
      32'h00000001, 32'hFFFFFFFE, 32'h00010000, 32'h0FF00FF0, 32'hF000F000, 32'hFFF0FFF0,
      32'h00000002, 32'h00000001, 32'd0, 32'd0, 32'd1, 32'd0,
      32'd1, 32'd0, 32'hDEADBEEF, 32'd5, 32'd1, 32'd0};
   localparam logic T_WR [NV] = '{
      1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
      1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
   localparam string T_REQ [NV] = '{
      "R1", "R1", "R1", "R2", "R2", "R2", "R3", "R3", "R3",
      "R3", "R4", "R4", "R4", "R4", "R5", "R6", "R6", "R8"};

   logic [31:0] div_a [L] = '{32'd100, 32'd100, 32'hFFFFFFFF, 32'd5,
                              32'd1000, 32'd0, 32'd77, 32'd12345};
   logic [31:0] div_b [L] = '{32'd7, 32'd0, 32'd1, 32'd9,
                              32'd10, 32'd3, 32'hFFFFFFFF, 32'd100};
   logic [31:0] exp_q [L] = '{32'd14, 32'd0, 32'hFFFFFFFF, 32'd0,
                              32'd100, 32'd0, 32'd0, 32'd123};
   logic [31:0] exp_r [L] = '{32'd2, 32'd0, 32'd0, 32'd5,
                              32'd0, 32'd0, 32'd77, 32'd45};

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic fill(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input logic [31:0] s);
      for (int i = 0; i < L; i++) begin
         src_a[i*W +: W] = a;
         src_b[i*W +: W] = b;
         src_c[i*W +: W] = c;
      end
      src_s = s;
   endtask

   task automatic run_div(input logic [3:0] op, input logic [L-1:0] mask,
                          input string req);
      int n;
      logic [31:0] expv;
      @(negedge clk);
      for (int i = 0; i < L; i++) begin
         src_a[i*W +: W] = div_a[i];
         src_b[i*W +: W] = div_b[i];
      end
      issue_op = op;
      lane_mask = mask;
      issue_valid = 1'b1;
      #2;
      check("R9", "no write in divide issue cycle", {24'd0, wr_en}, 32'd0);
      @(negedge clk);
      n = 1;
      fill(32'd1, 32'd1, 32'd0, 32'd0);
      issue_op = 4'd0;
      lane_mask = 8'hFF;
      #2;
      check("R10", "busy after divide issue", {31'd0, busy}, 32'd1);
      check("R10", "issue while busy writes nothing", {24'd0, wr_en}, 32'd0);
      @(negedge clk);
      issue_valid = 1'b0;
      n = 2;
      #2;
      while (wr_en == '0 && n < 100) begin
         @(negedge clk);
         n++;
         #2;
      end
      check("R9", "divide latency in cycles", n, W + 1);
      check("R9", "divide write mask", {24'd0, wr_en}, {24'd0, mask});
      for (int i = 0; i < L; i++) begin
         if (mask[i]) begin
            expv = (op == 4'd9) ? exp_r[i] : exp_q[i];
            check(req, $sformatf("divide lane %0d", i), wr_data[i*W +: W], expv);
         end
      end
      @(negedge clk);
      #2;
      check("R10", "busy low after divide write", {31'd0, busy}, 32'd0);
   endtask

   initial begin
      #(2_000_000);
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #2;
      check("R12", "busy in reset", {31'd0, busy}, 32'd0);
      check("R12", "div_err in reset", {31'd0, div_err}, 32'd0);
      check("R12", "wr_en in reset", {24'd0, wr_en}, 32'd0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         fill(T_A[k], T_B[k], T_C[k], T_S[k]);
         issue_op = T_OP[k];
         lane_mask = 8'hFF;
         issue_valid = 1'b1;
         #2;
         check(T_REQ[k], $sformatf("vector %0d wr_en", k), {24'd0, wr_en},
               T_WR[k] ? 32'hFF : 32'h0);
         if (T_WR[k]) begin
            for (int i = 0; i < L; i++) begin
               check(T_REQ[k], $sformatf("vector %0d lane %0d", k, i),
                     wr_data[i*W +: W], T_EXP[k]);
            end
         end
      end

      // R8: opcode 15 writes nothing
      @(negedge clk);
      issue_op = 4'd15;
      #2;
      check("R8", "opcode 15 wr_en", {24'd0, wr_en}, 32'd0);

      // R7: lane-distinct add with partial mask, then idle silence
      @(negedge clk);
      for (int i = 0; i < L; i++) begin
         src_a[i*W +: W] = i;
         src_b[i*W +: W] = 32'h100;
      end
      issue_op = 4'd0;
      lane_mask = 8'hA5;
      #2;
      check("R7", "partial mask wr_en", {24'd0, wr_en}, 32'hA5);
      for (int i = 0; i < L; i++) begin
         check("R7", $sformatf("add lane %0d", i), wr_data[i*W +: W], 32'h100 + i);
      end
      @(negedge clk);
      issue_valid = 1'b0;
      #2;
      check("R7", "no issue no write", {24'd0, wr_en}, 32'd0);

      // R9 R11: quotient with zero-divisor lane masked out
      run_div(4'd3, 8'hFD, "R9");
      check("R11", "masked zero divisor leaves flag clear", {31'd0, div_err}, 32'd0);
      // R11: remainder with zero-divisor lane enabled
      run_div(4'd9, 8'hFF, "R11");
      check("R11", "zero divisor raises flag", {31'd0, div_err}, 32'd1);
      @(negedge clk);
      fill(32'd4, 32'd5, 32'd0, 32'd0);
      issue_op = 4'd0;
      issue_valid = 1'b1;
      @(negedge clk);
      issue_valid = 1'b0;
      #2;
      check("R11", "flag stays set", {31'd0, div_err}, 32'd1);

      // R12: reset in the middle of a divide
      @(negedge clk);
      fill(32'd50, 32'd5, 32'd0, 32'd0);
      issue_op = 4'd3;
      issue_valid = 1'b1;
      @(negedge clk);
      issue_valid = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      #2;
      check("R12", "busy cleared by reset", {31'd0, busy}, 32'd0);
      check("R12", "flag cleared by reset", {31'd0, div_err}, 32'd0);
      check("R12", "no write after reset", {24'd0, wr_en}, 32'd0);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      #2;
      check("R12", "abandoned divide never writes", {24'd0, wr_en}, 32'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule